// File: doc/BRIEF.md
# Segmented Address Relocation Unit

This block turns a 16-bit offset and a reference class into a 20-bit physical byte address. It keeps four 16-bit segment base registers (extra, code, stack and data). For every request it chooses one of them from the kind of reference, lets an optional override replace that default where overrides are allowed, and forms the address as the chosen base moved up by four bit positions (one 16-byte paragraph) plus the offset. Any sum above the top of the 1 MiB space wraps around to its bottom.

The surrounding core presents a request together with an already computed offset, and receives the physical address and the index of the segment that was used. A write port loads any base register. A parameter chooses whether the address leaves the block in the same cycle as the request, or one cycle later from a register stage.

Top module: `seg_reloc_unit`

## Requirements
- R1: While reset is active `vld_o` is 0. After reset the code base holds `RESET_CODE` (default FFFFh) and the other three bases hold 0000h.
- R2: `pa_o` = (selected base × 16 + offset) mod 2^20, so any sum above FFFFFh wraps around to the bottom of the space.
- R3: Class 0 (instruction fetch) always uses the code segment. An override on the same request is ignored.
- R4: Class 1 (stack push or pop) and class 3 (data addressed from the BP base) use the stack segment unless an override is given.
- R5: Classes 2, 5, 6 and 7 (other data) use the data segment unless an override is given. When `ovr_vld_i` is 1 on a request of class 1, 2, 3, 5, 6 or 7, the segment is taken from `ovr_sel_i`.
- R6: Class 4 (string destination) always uses the extra segment. An override on the same request is ignored.
- R7: A write with `wr_en_i` loads `wr_data_i` into the base named by `wr_sel_i`. A request in the same cycle still sees the old value, and requests from the next cycle on see the new one.
- R8: With `OUT_REG`=0, `vld_o`, `seg_used_o` and `pa_o` follow the request in the same cycle. With `OUT_REG`=1 they appear one cycle later, and `seg_used_o` and `pa_o` hold their values while no request is present.
- R9: Segment indices are the same on `ovr_sel_i`, `wr_sel_i` and `seg_used_o`: 0 = extra, 1 = code, 2 = stack, 3 = data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_vld_i | input | 1 | Request present |
| req_cls_i | input | 3 | Reference class (see R3 to R6) |
| req_ofs_i | input | 16 | Offset inside the segment |
| ovr_vld_i | input | 1 | Segment override present |
| ovr_sel_i | input | 2 | Override segment index |
| wr_en_i | input | 1 | Base register write enable |
| wr_sel_i | input | 2 | Base register to write |
| wr_data_i | input | 16 | Base value to write |
| vld_o | output | 1 | Address valid |
| seg_used_o | output | 2 | Index of the segment that was used |
| pa_o | output | 20 | Physical byte address |

## Verification
The bench builds two copies of the block side by side, one with `OUT_REG`=0 and one with `OUT_REG`=1, both with the default 16-bit offset and 4-bit paragraph shift. The same stimulus drives both, so the same-cycle and the next-cycle timing of the address and of a base write can be compared against one model. Directed cases cover the reset base of the code segment, the wrap past FFFFFh, a write followed by a request in the same cycle, and overrides on fetch and on string destinations. After these, a long random stretch mixes every class with and without overrides, while writes go on in the background.

// File: rtl/seg_reloc_pkg.sv
package seg_reloc_pkg;

  localparam int NSEG  = 4;
  localparam int SEL_W = 2;
  localparam int CLS_W = 3;

  // Segment index: shared by override field, write port and report output.
  typedef enum logic [SEL_W-1:0] {
    SEG_EXTRA = 2'd0,
    SEG_CODE  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_DATA  = 2'd3
  } seg_id_e;

  // Reference classes; codes 5..7 behave as plain data.
  localparam logic [CLS_W-1:0] CLS_FETCH   = 3'd0;
  localparam logic [CLS_W-1:0] CLS_STACK   = 3'd1;
  localparam logic [CLS_W-1:0] CLS_DATA    = 3'd2;
  localparam logic [CLS_W-1:0] CLS_DATA_BP = 3'd3;
  localparam logic [CLS_W-1:0] CLS_STR_DST = 3'd4;

endpackage

// File: rtl/seg_rst_sync.sv
module seg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_reloc_pkg::*;
#(
  parameter int               OFS_W      = 16,
  parameter logic [OFS_W-1:0] RESET_CODE = '1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en_i,
  input  logic [SEL_W-1:0]            wr_sel_i,
  input  logic [OFS_W-1:0]            wr_data_i,
  output logic [NSEG-1:0][OFS_W-1:0]  bank_o
);

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    localparam logic [OFS_W-1:0] RST_VAL =
      (g == int'(SEG_CODE)) ? RESET_CODE : '0;

    logic             ld_en;
    logic [OFS_W-1:0] base_d;
    logic [OFS_W-1:0] base_q;

    always_comb begin
      ld_en  = wr_en_i && (wr_sel_i == SEL_W'(g));
      base_d = wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q <= RST_VAL;
      end else if (ld_en) begin
        base_q <= base_d;
      end
    end

    assign bank_o[g] = base_q;
  end

endmodule

// File: rtl/seg_select.sv
module seg_select
  import seg_reloc_pkg::*;
(
  input  logic [CLS_W-1:0] cls_i,
  input  logic             ovr_vld_i,
  input  logic [SEL_W-1:0] ovr_sel_i,
  output seg_id_e          sel_o
);

  seg_id_e dflt;
  logic    fixed_cls;

  always_comb begin
    fixed_cls = 1'b0;
    case (cls_i)
      CLS_FETCH: begin
        dflt      = SEG_CODE;
        fixed_cls = 1'b1;
      end
      CLS_STR_DST: begin
        dflt      = SEG_EXTRA;
        fixed_cls = 1'b1;
      end
      CLS_STACK, CLS_DATA_BP: dflt = SEG_STACK;
      default:                dflt = SEG_DATA;
    endcase
  end

  always_comb begin
    if (ovr_vld_i && !fixed_cls) begin
      sel_o = seg_id_e'(ovr_sel_i);
    end else begin
      sel_o = dflt;
    end
  end

endmodule

// File: rtl/seg_adder.sv
module seg_adder #(
  parameter int OFS_W = 16,
  parameter int SHIFT = 4,
  parameter int PA_W  = OFS_W + SHIFT
) (
  input  logic [OFS_W-1:0] base_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic [PA_W-1:0]  pa_o
);

  logic [PA_W-1:0] base_ext;
  logic [PA_W-1:0] ofs_ext;

  always_comb begin
    base_ext = {base_i, {SHIFT{1'b0}}};
    ofs_ext  = {{SHIFT{1'b0}}, ofs_i};
    pa_o     = base_ext + ofs_ext;
  end

endmodule

// File: rtl/seg_reloc_unit.sv
module seg_reloc_unit
  import seg_reloc_pkg::*;
#(
  parameter int               OFS_W      = 16,
  parameter int               SHIFT      = 4,
  parameter bit               OUT_REG    = 1'b0,
  parameter logic [OFS_W-1:0] RESET_CODE = 16'hFFFF,
  localparam int              PA_W       = OFS_W + SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_vld_i,
  input  logic [2:0]       req_cls_i,
  input  logic [OFS_W-1:0] req_ofs_i,
  input  logic             ovr_vld_i,
  input  logic [1:0]       ovr_sel_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [OFS_W-1:0] wr_data_i,
  output logic             vld_o,
  output logic [1:0]       seg_used_o,
  output logic [PA_W-1:0]  pa_o
);

  logic                       rst_sync_n;
  logic [NSEG-1:0][OFS_W-1:0] seg_bank;
  seg_id_e                    sel_id;
  logic [OFS_W-1:0]           sel_base;
  logic [PA_W-1:0]            pa_comb;
  logic                       vld_comb;

  seg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  seg_regfile #(.OFS_W(OFS_W), .RESET_CODE(RESET_CODE)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .bank_o    (seg_bank)
  );

  seg_select u_sel (
    .cls_i     (req_cls_i),
    .ovr_vld_i (ovr_vld_i),
    .ovr_sel_i (ovr_sel_i),
    .sel_o     (sel_id)
  );

  always_comb begin
    sel_base = seg_bank[sel_id];
    vld_comb = req_vld_i && rst_sync_n;
  end

  seg_adder #(.OFS_W(OFS_W), .SHIFT(SHIFT), .PA_W(PA_W)) u_add (
    .base_i (sel_base),
    .ofs_i  (req_ofs_i),
    .pa_o   (pa_comb)
  );

  if (OUT_REG) begin : g_out_reg
    logic            vld_q;
    logic [1:0]      seg_q;
    logic [PA_W-1:0] pa_q;
    logic            cap_en;
    logic [1:0]      seg_d;
    logic [PA_W-1:0] pa_d;

    always_comb begin
      cap_en = req_vld_i;
      seg_d  = sel_id;
      pa_d   = pa_comb;
    end

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) begin
        vld_q <= 1'b0;
      end else begin
        vld_q <= req_vld_i;
      end
    end

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) begin
        seg_q <= '0;
        pa_q  <= '0;
      end else if (cap_en) begin
        seg_q <= seg_d;
        pa_q  <= pa_d;
      end
    end

    assign vld_o      = vld_q;
    assign seg_used_o = seg_q;
    assign pa_o       = pa_q;
  end else begin : g_out_comb
    assign vld_o      = vld_comb;
    assign seg_used_o = sel_id;
    assign pa_o       = pa_comb;
  end

endmodule

// File: rtl/seg_reloc_chk.sv
module seg_reloc_chk
  import seg_reloc_pkg::*;
#(
  parameter int OFS_W   = 16,
  parameter bit OUT_REG = 1'b0
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_vld_i,
  input logic [2:0]                 req_cls_i,
  input logic                       ovr_vld_i,
  input logic [1:0]                 ovr_sel_i,
  input logic                       wr_en_i,
  input logic [1:0]                 wr_sel_i,
  input logic [OFS_W-1:0]           wr_data_i,
  input logic                       vld_o,
  input seg_id_e                    sel,
  input logic [NSEG-1:0][OFS_W-1:0] bank
);

  assert_fetch_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld_i && req_cls_i == CLS_FETCH) |-> sel == SEG_CODE);

  assert_stack_default_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld_i && !ovr_vld_i &&
     (req_cls_i == CLS_STACK || req_cls_i == CLS_DATA_BP)) |-> sel == SEG_STACK);

  assert_override_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld_i && ovr_vld_i && req_cls_i != CLS_FETCH && req_cls_i != CLS_STR_DST)
      |-> sel == seg_id_e'(ovr_sel_i));

  assert_strdst_extra_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld_i && req_cls_i == CLS_STR_DST) |-> sel == SEG_EXTRA);

  assert_write_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> bank[$past(wr_sel_i)] == $past(wr_data_i));

  if (OUT_REG) begin : g_reg_chk
    assert_vld_lag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld_i |=> vld_o);
    assert_idle_lag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !req_vld_i |=> !vld_o);
  end else begin : g_comb_chk
    assert_vld_same_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld_i |-> vld_o);
  end

endmodule

bind seg_reloc_unit seg_reloc_chk #(.OFS_W(OFS_W), .OUT_REG(OUT_REG)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .req_vld_i (req_vld_i),
  .req_cls_i (req_cls_i),
  .ovr_vld_i (ovr_vld_i),
  .ovr_sel_i (ovr_sel_i),
  .wr_en_i   (wr_en_i),
  .wr_sel_i  (wr_sel_i),
  .wr_data_i (wr_data_i),
  .vld_o     (vld_o),
  .sel       (sel_id),
  .bank      (seg_bank)
);

// File: tb/tb_seg_reloc_unit.sv
module tb_seg_reloc_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_vld;
  logic [2:0]  req_cls;
  logic [15:0] req_ofs;
  logic        ovr_vld;
  logic [1:0]  ovr_sel;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [15:0] wr_data;
  logic        vld_c, vld_r;
  logic [1:0]  seg_c, seg_r;
  logic [19:0] pa_c, pa_r;

  int checks   = 0;
  int failures = 0;

  logic [15:0] seg_m [4];
  bit          sv_vld;
  logic [1:0]  sv_seg;
  logic [19:0] sv_pa;
  bit          sv_any = 1'b0;

  always #2 clk = ~clk;

  seg_reloc_unit #(.OUT_REG(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .req_vld_i(req_vld), .req_cls_i(req_cls),
    .req_ofs_i(req_ofs), .ovr_vld_i(ovr_vld), .ovr_sel_i(ovr_sel),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .vld_o(vld_c), .seg_used_o(seg_c), .pa_o(pa_c));

  seg_reloc_unit #(.OUT_REG(1'b1)) dut_reg (
    .clk(clk), .rst_n(rst_n), .req_vld_i(req_vld), .req_cls_i(req_cls),
    .req_ofs_i(req_ofs), .ovr_vld_i(ovr_vld), .ovr_sel_i(ovr_sel),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .vld_o(vld_r), .seg_used_o(seg_r), .pa_o(pa_r));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Segment choice from R3..R6, indices from R9.
  function automatic logic [1:0] ref_seg(input logic [2:0] cls, input bit ov,
                                         input logic [1:0] os);
    if (cls == 3'd0) return 2'd1;
    if (cls == 3'd4) return 2'd0;
    if (ov) return os;
    if (cls == 3'd1 || cls == 3'd3) return 2'd2;
    return 2'd3;
  endfunction

  function automatic string seg_tag(input logic [2:0] cls, input bit ov);
    if (cls == 3'd0) return "R3";
    if (cls == 3'd4) return "R6";
    if (ov) return "R5";
    if (cls == 3'd1 || cls == 3'd3) return "R4";
    return "R5";
  endfunction

  // One clock: starts and ends at a falling edge.
  task automatic cyc(input bit v, input logic [2:0] cls, input logic [15:0] ofs,
                     input bit ov, input logic [1:0] os, input bit we,
                     input logic [1:0] ws, input logic [15:0] wd, input string tag);
    logic [1:0]  es;
    logic [19:0] ep;
    req_vld = v; req_cls = cls; req_ofs = ofs; ovr_vld = ov; ovr_sel = os;
    wr_en = we; wr_sel = ws; wr_data = wd;
    #1;
    es = ref_seg(cls, ov, os);
    ep = {seg_m[es], 4'h0} + {4'h0, ofs};
    check(vld_c == v, "R8", "comb vld", 32'(vld_c), 32'(v));
    if (v) begin
      check(seg_c == es, seg_tag(cls, ov), "comb seg", 32'(seg_c), 32'(es));
      check(pa_c == ep, tag, "comb pa", 32'(pa_c), 32'(ep));
    end
    @(posedge clk);
    if (we) seg_m[ws] = wd;
    sv_vld = v;
    if (v) begin
      sv_seg = es; sv_pa = ep; sv_any = 1'b1;
    end
    @(negedge clk);
    check(vld_r == sv_vld, "R8", "reg vld", 32'(vld_r), 32'(sv_vld));
    if (sv_any) begin
      check(seg_r == sv_seg, "R8", "reg seg", 32'(seg_r), 32'(sv_seg));
      check(pa_r == sv_pa, "R8", "reg pa", 32'(pa_r), 32'(sv_pa));
    end
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_vld = 1'b1; req_cls = 3'd0; req_ofs = '0; ovr_vld = 1'b0; ovr_sel = '0;
    wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    seg_m[0] = 16'h0000; seg_m[1] = 16'hFFFF; seg_m[2] = 16'h0000; seg_m[3] = 16'h0000;
    repeat (3) @(negedge clk);
    check(vld_c == 1'b0, "R1", "vld in reset (comb)", 32'(vld_c), 0);
    check(vld_r == 1'b0, "R1", "vld in reset (reg)", 32'(vld_r), 0);
    req_vld = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: code base after reset, fetch at offset 0 -> FFFF0
    cyc(1, 3'd0, 16'h0000, 0, 2'd0, 0, 2'd0, 16'h0, "R1");
    cyc(1, 3'd2, 16'h0000, 0, 2'd0, 0, 2'd0, 16'h0, "R1");
    // R7: write data base, same-cycle request sees old value
    cyc(1, 3'd2, 16'h0005, 0, 2'd0, 1, 2'd3, 16'h1234, "R7");
    cyc(1, 3'd2, 16'h0005, 0, 2'd0, 0, 2'd0, 16'h0, "R7");
    // R2: wrap past FFFFF (stack FFFF:0020 -> 00010)
    cyc(0, 3'd0, 16'h0000, 0, 2'd0, 1, 2'd2, 16'hFFFF, "R2");
    cyc(1, 3'd1, 16'h0020, 0, 2'd0, 0, 2'd0, 16'h0, "R2");
    cyc(1, 3'd3, 16'hFFFF, 0, 2'd0, 0, 2'd0, 16'h0, "R2");
    // R6: string destination ignores override
    cyc(0, 3'd0, 16'h0000, 0, 2'd0, 1, 2'd0, 16'h2000, "R6");
    cyc(1, 3'd4, 16'h00AB, 1, 2'd3, 0, 2'd0, 16'h0, "R6");
    // R3: fetch ignores override
    cyc(1, 3'd0, 16'h0010, 1, 2'd2, 0, 2'd0, 16'h0, "R3");
    // R5: overrides on data, stack and BP-relative classes, and class 6 default
    cyc(1, 3'd2, 16'h0100, 1, 2'd0, 0, 2'd0, 16'h0, "R5");
    cyc(1, 3'd1, 16'h0100, 1, 2'd1, 0, 2'd0, 16'h0, "R5");
    cyc(1, 3'd3, 16'h0100, 1, 2'd3, 0, 2'd0, 16'h0, "R5");
    cyc(1, 3'd6, 16'h0042, 0, 2'd0, 0, 2'd0, 16'h0, "R5");
    // R8: idle cycle, registered outputs hold
    cyc(0, 3'd2, 16'h7777, 0, 2'd0, 0, 2'd0, 16'h0, "R8");
    // Random mix
    for (int i = 0; i < 600; i++) begin
      cyc(1'($urandom), 3'($urandom), 16'($urandom), 1'($urandom),
          2'($urandom), ($urandom % 4) == 0, 2'($urandom), 16'($urandom), "R2");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule